// File: doc/BRIEF.md
# Per-CPU Priority Interrupt Selector

This block sits behind one CPU interrupt output of a multi-source interrupt controller. Upstream routing logic offers it deliveries, each naming a source slot and that source's priority. The block either records the source in its raised set or turns the delivery away. It turns it away when the priority does not beat the CPU's current task priority, or when the source is already raised (a miss). Every slot keeps the priority it was raised with.

From the raised set the block picks a winner: the highest stored priority, with the lowest slot number winning a tie. It publishes the winner's slot number and priority on a registered read port, or minus one in both fields when nothing is raised. A CPU interrupt request output rises when an accepted delivery beats the currently published priority. It falls as soon as no raised source stands above the task priority. A clear input removes one slot from the raised set, and a write port loads the task priority.

Top module: `cpu_prio_selector`

## Requirements
- R1: After reset the raised set is empty, the task priority reads 0x0F, the selection reads slot -1 and priority -1, and the interrupt request is low.
- R2: A delivery whose priority is less than or equal to the task priority returns response code 2 (low) in the same cycle and does not raise the source.
- R3: A delivery to an already raised source with priority above the task priority returns response code 3 (miss) and leaves the stored priority unchanged.
- R4: Any other valid delivery returns response code 1 (accept) and raises the source. The selection reflects it after the second rising edge following the delivery cycle. Code 0 means no delivery is offered.
- R5: The selection is the raised source with the strictly highest priority; among equal priorities the lowest slot number is chosen.
- R6: With nothing raised, the selection reads slot -1 and priority -1 (all ones in both signed fields).
- R7: The interrupt request rises at the edge that accepts a delivery whose priority exceeds the published selection priority. Lowering the task priority alone never raises it.
- R8: The interrupt request falls at the edge after which no raised source has a priority above the task priority.
- R9: A task priority write stores only the low 4 bits of the written byte; the upper read-back bits are zero.
- R10: A clear removes the named slot from the raised set. A clear of a slot that is not raised has no effect. A clear and a delivery to the same slot in the same cycle leave the slot raised when the delivery is accepted.
- R11: Raising the task priority does not remove any source from the raised set or change the selection.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dlv_valid | input | 1 | Delivery offered this cycle |
| dlv_src | input | 6 | Slot number of the delivered source |
| dlv_prio | input | 5 | Priority of the delivered source |
| dlv_resp | output | 2 | Same-cycle response: 0 none, 1 accept, 2 low, 3 miss |
| clr_valid | input | 1 | Clear request this cycle |
| clr_src | input | 6 | Slot number to clear |
| tpr_we | input | 1 | Task priority write strobe |
| tpr_wdata | input | 8 | Task priority write data |
| tpr_rdata | output | 8 | Task priority read-back |
| sel_src | output | 7 | Selected slot, signed, -1 for none |
| sel_prio | output | 6 | Selected priority, signed, -1 for none |
| cpu_irq | output | 1 | Interrupt request to the CPU |

## Verification
The hardest state to reach is one where the interrupt request must stay low even though a raised source beats the task priority. To get there, the request is first dropped by raising the task priority, and the task priority is then lowered again with no new delivery. A low-priority delivery that is accepted but does not beat the published winner then has to leave the request low. Only after that does a delivery that beats the winner raise it. Priority ties sit on slots whose numbers are out of order relative to their arrival. This shows that slot number, and not arrival order, breaks the tie.

// File: rtl/prisel_pkg.sv
package prisel_pkg;

   // Response code returned on a delivery in the same cycle.
   typedef enum logic [1:0] {
      RESP_NONE   = 2'd0,
      RESP_ACCEPT = 2'd1,
      RESP_LOW    = 2'd2,
      RESP_MISS   = 2'd3
   } dlv_resp_e;

   // Winner search implementations.
   localparam int SEL_TREE   = 0;
   localparam int SEL_LINEAR = 1;

endpackage

// File: rtl/prisel_slot_store.sv
module prisel_slot_store #(
   parameter int N_SRC  = 64,
   parameter int PRIO_W = 5,
   localparam int IDX_W = $clog2(N_SRC)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          set_en,
   input  logic [IDX_W-1:0]              set_idx,
   input  logic [PRIO_W-1:0]             set_prio,
   input  logic                          clr_en,
   input  logic [IDX_W-1:0]              clr_idx,
   output logic [N_SRC-1:0]              raised_q,
   output logic [N_SRC-1:0][PRIO_W-1:0]  prio_q,
   output logic [N_SRC-1:0]              raised_d,
   output logic [N_SRC-1:0][PRIO_W-1:0]  prio_d
);

   generate
      for (genvar g = 0; g < N_SRC; g++) begin : g_slot
         localparam logic [IDX_W-1:0] SLOT = IDX_W'(g);
         logic              r_q, r_d;
         logic [PRIO_W-1:0] p_q, p_d;

         // A set in the same cycle as a clear of the same slot wins.
         always_comb begin
            r_d = r_q;
            p_d = p_q;
            if (clr_en && (clr_idx == SLOT)) begin
               r_d = 1'b0;
            end
            if (set_en && (set_idx == SLOT)) begin
               r_d = 1'b1;
               p_d = set_prio;
            end
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               r_q <= 1'b0;
               p_q <= '0;
            end else begin
               r_q <= r_d;
               p_q <= p_d;
            end
         end

         assign raised_q[g] = r_q;
         assign prio_q[g]   = p_q;
         assign raised_d[g] = r_d;
         assign prio_d[g]   = p_d;
      end
   endgenerate

   // R10: a clear that is not overridden by a same-slot set empties the slot.
   a_r10_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_en && !(set_en && (set_idx == clr_idx))) |=> !raised_q[$past(clr_idx)]);

   // R4: a set always leaves the slot raised with the offered priority.
   a_r4_set_holds: assert property (@(posedge clk) disable iff (!rst_n)
      set_en |=> (raised_q[$past(set_idx)] && (prio_q[$past(set_idx)] == $past(set_prio))));

endmodule

// File: rtl/prisel_winner.sv
module prisel_winner #(
   parameter int N_SRC     = 64,
   parameter int PRIO_W    = 5,
   parameter int SEL_STYLE = prisel_pkg::SEL_TREE,
   localparam int IDX_W    = $clog2(N_SRC)
) (
   input  logic [N_SRC-1:0]              raised,
   input  logic [N_SRC-1:0][PRIO_W-1:0]  prio,
   output logic                          win_valid,
   output logic [IDX_W-1:0]              win_idx,
   output logic [PRIO_W-1:0]             win_prio
);

   generate
      if (SEL_STYLE == prisel_pkg::SEL_TREE) begin : g_tree
         if ((1 << IDX_W) != N_SRC) begin : g_bad_depth
            $error("prisel_winner: tree search needs a power-of-two slot count");
         end

         // Heap-ordered tree: node n has children 2n and 2n+1; leaves at N_SRC..2*N_SRC-1.
         logic [2*N_SRC-1:0]             nv;
         logic [2*N_SRC-1:0][IDX_W-1:0]  ni;
         logic [2*N_SRC-1:0][PRIO_W-1:0] np;

         assign nv[0] = 1'b0;
         assign ni[0] = '0;
         assign np[0] = '0;

         for (genvar l = 0; l < N_SRC; l++) begin : g_leaf
            assign nv[N_SRC+l] = raised[l];
            assign ni[N_SRC+l] = IDX_W'(l);
            assign np[N_SRC+l] = prio[l];
         end

         for (genvar n = 1; n < N_SRC; n++) begin : g_node
            logic take_left;
            // Left subtree holds lower slot numbers, so it keeps ties.
            assign take_left = nv[2*n] && (!nv[2*n+1] || (np[2*n] >= np[2*n+1]));
            assign nv[n] = nv[2*n] || nv[2*n+1];
            assign ni[n] = take_left ? ni[2*n] : ni[2*n+1];
            assign np[n] = take_left ? np[2*n] : np[2*n+1];
         end

         assign win_valid = nv[1];
         assign win_idx   = ni[1];
         assign win_prio  = np[1];
      end else begin : g_linear
         always_comb begin
            win_valid = 1'b0;
            win_idx   = '0;
            win_prio  = '0;
            // Walking downward with >= lets the lowest slot keep a tie.
            for (int i = N_SRC - 1; i >= 0; i--) begin
               if (raised[i] && (!win_valid || (prio[i] >= win_prio))) begin
                  win_valid = 1'b1;
                  win_idx   = IDX_W'(i);
                  win_prio  = prio[i];
               end
            end
         end
      end
   endgenerate

   // R5: the winner is always a raised slot and carries that slot's priority.
   always_comb begin
      if (win_valid) begin
         a_r5_winner_raised: assert (raised[win_idx] && (prio[win_idx] == win_prio));
      end
   end

endmodule

// File: rtl/prisel_threshold.sv
module prisel_threshold #(
   parameter int N_SRC  = 64,
   parameter int PRIO_W = 5,
   parameter int TPR_W  = 4
) (
   input  logic [N_SRC-1:0]              raised,
   input  logic [N_SRC-1:0][PRIO_W-1:0]  prio,
   input  logic [TPR_W-1:0]              tpr,
   output logic                          any_above
);

   logic [PRIO_W-1:0] tpr_ext;
   logic [N_SRC-1:0]  above;

   assign tpr_ext = PRIO_W'(tpr);

   generate
      for (genvar g = 0; g < N_SRC; g++) begin : g_cmp
         assign above[g] = raised[g] && (prio[g] > tpr_ext);
      end
   endgenerate

   assign any_above = |above;

endmodule

// File: rtl/cpu_prio_selector.sv
module cpu_prio_selector #(
   parameter int N_SRC     = 64,
   parameter int PRIO_W    = 5,
   parameter int TPR_W     = 4,
   parameter int BUS_W     = 8,
   parameter int TPR_RST   = 15,
   parameter int SEL_STYLE = prisel_pkg::SEL_TREE,
   localparam int IDX_W    = $clog2(N_SRC)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     dlv_valid,
   input  logic [IDX_W-1:0]         dlv_src,
   input  logic [PRIO_W-1:0]        dlv_prio,
   output logic [1:0]               dlv_resp,
   input  logic                     clr_valid,
   input  logic [IDX_W-1:0]         clr_src,
   input  logic                     tpr_we,
   input  logic [BUS_W-1:0]         tpr_wdata,
   output logic [BUS_W-1:0]         tpr_rdata,
   output logic signed [IDX_W:0]    sel_src,
   output logic signed [PRIO_W:0]   sel_prio,
   output logic                     cpu_irq
);
   import prisel_pkg::*;

   localparam logic [TPR_W-1:0] TPR_INIT = TPR_W'(TPR_RST);

   if (N_SRC < 2) begin : g_chk_src
      $error("cpu_prio_selector: at least two slots required");
   end
   if (TPR_W > PRIO_W) begin : g_chk_tpr
      $error("cpu_prio_selector: task priority wider than source priority");
   end
   if (BUS_W < TPR_W) begin : g_chk_bus
      $error("cpu_prio_selector: write data narrower than task priority");
   end
   if (TPR_RST >= (1 << TPR_W)) begin : g_chk_rst
      $error("cpu_prio_selector: task priority reset value does not fit");
   end

   logic [TPR_W-1:0]               tpr_q, tpr_d;
   logic [N_SRC-1:0]               raised_q, raised_d;
   logic [N_SRC-1:0][PRIO_W-1:0]   prio_q, prio_d;
   logic                           win_valid;
   logic [IDX_W-1:0]               win_idx;
   logic [PRIO_W-1:0]              win_prio;
   logic                           any_above_d;
   logic                           prio_beats_tpr;
   logic                           set_en;
   logic                           fire;
   logic signed [IDX_W:0]          sel_src_q;
   logic signed [PRIO_W:0]         sel_prio_q;
   logic                           irq_q;
   dlv_resp_e                      resp;

   // ---------------- task priority ----------------
   assign tpr_d = tpr_we ? tpr_wdata[TPR_W-1:0] : tpr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tpr_q <= TPR_INIT;
      else        tpr_q <= tpr_d;
   end

   assign tpr_rdata = BUS_W'(tpr_q);

   // ---------------- delivery decision ----------------
   assign prio_beats_tpr = dlv_prio > PRIO_W'(tpr_q);

   always_comb begin
      if (!dlv_valid)               resp = RESP_NONE;
      else if (!prio_beats_tpr)     resp = RESP_LOW;
      else if (raised_q[dlv_src])   resp = RESP_MISS;
      else                          resp = RESP_ACCEPT;
   end

   assign dlv_resp = resp;
   assign set_en   = (resp == RESP_ACCEPT);

   // ---------------- raised set ----------------
   prisel_slot_store #(
      .N_SRC  (N_SRC),
      .PRIO_W (PRIO_W)
   ) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_en   (set_en),
      .set_idx  (dlv_src),
      .set_prio (dlv_prio),
      .clr_en   (clr_valid),
      .clr_idx  (clr_src),
      .raised_q (raised_q),
      .prio_q   (prio_q),
      .raised_d (raised_d),
      .prio_d   (prio_d)
   );

   // ---------------- winner search ----------------
   prisel_winner #(
      .N_SRC     (N_SRC),
      .PRIO_W    (PRIO_W),
      .SEL_STYLE (SEL_STYLE)
   ) u_winner (
      .raised    (raised_q),
      .prio      (prio_q),
      .win_valid (win_valid),
      .win_idx   (win_idx),
      .win_prio  (win_prio)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_src_q  <= '1;
         sel_prio_q <= '1;
      end else if (win_valid) begin
         sel_src_q  <= $signed({1'b0, win_idx});
         sel_prio_q <= $signed({1'b0, win_prio});
      end else begin
         sel_src_q  <= '1;
         sel_prio_q <= '1;
      end
   end

   assign sel_src  = sel_src_q;
   assign sel_prio = sel_prio_q;

   // ---------------- interrupt request ----------------
   prisel_threshold #(
      .N_SRC  (N_SRC),
      .PRIO_W (PRIO_W),
      .TPR_W  (TPR_W)
   ) u_thresh (
      .raised    (raised_d),
      .prio      (prio_d),
      .tpr       (tpr_d),
      .any_above (any_above_d)
   );

   assign fire = set_en && ($signed({1'b0, dlv_prio}) > sel_prio_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= (irq_q || fire) && any_above_d;
   end

   assign cpu_irq = irq_q;

   // ---------------- assertions ----------------
   // R2: a delivery that does not beat the task priority never raises an idle slot.
   a_r2_low_no_raise: assert property (@(posedge clk) disable iff (!rst_n)
      (dlv_valid && (dlv_prio <= PRIO_W'(tpr_q)) && !raised_q[dlv_src])
      |=> !raised_q[$past(dlv_src)]);

   // R3: a miss leaves the stored priority of that slot untouched.
   a_r3_miss_keeps_prio: assert property (@(posedge clk) disable iff (!rst_n)
      (dlv_resp == RESP_MISS) |=> (prio_q[$past(dlv_src)] == $past(prio_q[dlv_src])));

   // R6: an empty raised set publishes minus one in both fields.
   a_r6_empty_none: assert property (@(posedge clk) disable iff (!rst_n)
      (raised_q == '0) |=> ((&sel_src_q) && (&sel_prio_q)));

   // R7: the request only rises on an edge that accepted a delivery.
   a_r7_rise_needs_accept: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_q) |-> $past(dlv_resp == RESP_ACCEPT));

   // R8: with nothing above the task priority the request is low after the edge.
   a_r8_drop_when_none: assert property (@(posedge clk) disable iff (!rst_n)
      !any_above_d |=> !irq_q);

   // R9: the upper read-back bits of the task priority are zero.
   a_r9_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      tpr_we |=> ((tpr_rdata >> TPR_W) == '0));

endmodule

// File: tb/cpu_prio_selector_tb.sv
module cpu_prio_selector_tb;

   localparam int OP_IDLE = 0;
   localparam int OP_DLV  = 1;
   localparam int OP_CLR  = 2;
   localparam int OP_TPR  = 3;

   typedef struct packed {
      logic [1:0]        op;
      logic [5:0]        src;
      logic [7:0]        val;
      logic [1:0]        resp;
      logic signed [6:0] esrc;
      logic signed [5:0] eprio;
      logic              eirq;
      logic [3:0]        req;
   } vec_t;

   localparam int NV = 19;
   localparam vec_t VEC [NV] = '{
      '{2'd1, 6'd5,  8'd3,   2'd2, -7'sd1, -6'sd1, 1'b0, 4'd2 },  // R2 below reset TPR
      '{2'd3, 6'd0,  8'hF2,  2'd0, -7'sd1, -6'sd1, 1'b0, 4'd9 },  // R9 TPR <- 2
      '{2'd1, 6'd5,  8'd2,   2'd2, -7'sd1, -6'sd1, 1'b0, 4'd2 },  // R2 equal to TPR
      '{2'd1, 6'd5,  8'd3,   2'd1,  7'sd5,  6'sd3, 1'b1, 4'd4 },  // R4 R7 accept
      '{2'd1, 6'd5,  8'd9,   2'd3,  7'sd5,  6'sd3, 1'b1, 4'd3 },  // R3 miss
      '{2'd1, 6'd40, 8'd9,   2'd1,  7'sd40, 6'sd9, 1'b1, 4'd5 },  // R5 higher wins
      '{2'd1, 6'd12, 8'd9,   2'd1,  7'sd12, 6'sd9, 1'b1, 4'd5 },  // R5 tie lowest slot
      '{2'd1, 6'd63, 8'd31,  2'd1,  7'sd63, 6'sd31,1'b1, 4'd5 },  // R5 top slot, top prio
      '{2'd2, 6'd63, 8'd0,   2'd0,  7'sd12, 6'sd9, 1'b1, 4'd10},  // R10 clear
      '{2'd2, 6'd12, 8'd0,   2'd0,  7'sd40, 6'sd9, 1'b1, 4'd10},  // R10 clear
      '{2'd2, 6'd7,  8'd0,   2'd0,  7'sd40, 6'sd9, 1'b1, 4'd10},  // R10 clear idle slot
      '{2'd3, 6'd0,  8'd9,   2'd0,  7'sd40, 6'sd9, 1'b0, 4'd8 },  // R8 R11 TPR <- 9
      '{2'd3, 6'd0,  8'd0,   2'd0,  7'sd40, 6'sd9, 1'b0, 4'd7 },  // R7 TPR lowered, no rise
      '{2'd1, 6'd0,  8'd1,   2'd1,  7'sd40, 6'sd9, 1'b0, 4'd7 },  // R7 accept below winner
      '{2'd1, 6'd1,  8'd20,  2'd1,  7'sd1,  6'sd20,1'b1, 4'd7 },  // R7 beats winner
      '{2'd2, 6'd1,  8'd0,   2'd0,  7'sd40, 6'sd9, 1'b1, 4'd8 },  // R8 still above
      '{2'd2, 6'd40, 8'd0,   2'd0,  7'sd5,  6'sd3, 1'b1, 4'd5 },  // R5 fall back
      '{2'd2, 6'd5,  8'd0,   2'd0,  7'sd0,  6'sd1, 1'b1, 4'd5 },  // R5 fall back
      '{2'd2, 6'd0,  8'd0,   2'd0, -7'sd1, -6'sd1, 1'b0, 4'd6 }   // R6 R8 empty
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              dlv_valid = 1'b0;
   logic [5:0]        dlv_src = '0;
   logic [4:0]        dlv_prio = '0;
   logic [1:0]        dlv_resp;
   logic              clr_valid = 1'b0;
   logic [5:0]        clr_src = '0;
   logic              tpr_we = 1'b0;
   logic [7:0]        tpr_wdata = '0;
   logic [7:0]        tpr_rdata;
   logic signed [6:0] sel_src;
   logic signed [5:0] sel_prio;
   logic              cpu_irq;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   cpu_prio_selector u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .dlv_valid (dlv_valid),
      .dlv_src   (dlv_src),
      .dlv_prio  (dlv_prio),
      .dlv_resp  (dlv_resp),
      .clr_valid (clr_valid),
      .clr_src   (clr_src),
      .tpr_we    (tpr_we),
      .tpr_wdata (tpr_wdata),
      .tpr_rdata (tpr_rdata),
      .sel_src   (sel_src),
      .sel_prio  (sel_prio),
      .cpu_irq   (cpu_irq)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // Drive one operation for one cycle, return the same-cycle response,
   // then idle one more cycle so the registered selection catches up.
   task automatic apply(input int op, input int src, input int val, input bit also_clr,
                        output int resp);
      @(negedge clk);
      dlv_valid = (op == OP_DLV);
      clr_valid = (op == OP_CLR) || also_clr;
      tpr_we    = (op == OP_TPR);
      dlv_src   = 6'(src);
      clr_src   = 6'(src);
      dlv_prio  = 5'(val);
      tpr_wdata = 8'(val);
      #1 resp = int'(dlv_resp);
      @(negedge clk);
      dlv_valid = 1'b0;
      clr_valid = 1'b0;
      tpr_we    = 1'b0;
      @(negedge clk);
      #1;
   endtask

   task automatic chk_sel(input string req, input int es, input int ep, input int ei);
      chk(req, "sel_src", int'(sel_src), es);
      chk(req, "sel_prio", int'(sel_prio), ep);
      chk(req, "cpu_irq", int'(cpu_irq), ei);
   endtask

   initial begin
      #2_000_000;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int r;
      repeat (3) @(negedge clk);
      #1;
      // R1 values while reset is held
      chk_sel("R1", -1, -1, 0);
      chk("R1", "tpr_rdata", int'(tpr_rdata), 15);
      rst_n = 1'b1;
      @(negedge clk);
      #1 chk_sel("R1", -1, -1, 0);

      for (int i = 0; i < NV; i++) begin
         string tag;
         tag = $sformatf("R%0d vec%0d", VEC[i].req, i);
         apply(int'(VEC[i].op), int'(VEC[i].src), int'(VEC[i].val), 1'b0, r);
         chk(tag, "dlv_resp", r, int'(VEC[i].resp));
         chk_sel(tag, int'(VEC[i].esrc), int'(VEC[i].eprio), int'(VEC[i].eirq));
         if (i == 1) chk("R9", "tpr_rdata", int'(tpr_rdata), 2);
      end

      // R10: clear and accepted delivery to one slot in one cycle keeps it raised
      apply(OP_DLV, 7, 5, 1'b1, r);
      chk("R10", "dlv_resp", r, 1);
      chk_sel("R10", 7, 5, 1);

      // R9: only the low nibble is stored; R8 drops the request (5 is not above 11)
      apply(OP_TPR, 0, 8'hAB, 1'b0, r);
      chk("R9", "tpr_rdata", int'(tpr_rdata), 8'h0B);
      chk_sel("R11", 7, 5, 0);

      // R1: reset mid-run restores the idle state
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk_sel("R1", -1, -1, 0);
      chk("R1", "tpr_rdata", int'(tpr_rdata), 15);

      // R2 with reset TPR, then R1 (set empty) means slot 7 is accepted, not missed
      apply(OP_DLV, 7, 15, 1'b0, r);
      chk("R2", "dlv_resp", r, 2);
      apply(OP_DLV, 7, 20, 1'b0, r);
      chk("R1", "dlv_resp", r, 1);
      chk_sel("R4", 7, 20, 1);

      // R4 code 0 when nothing is offered
      apply(OP_IDLE, 0, 0, 1'b0, r);
      chk("R4", "dlv_resp", r, 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule